// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This is a purely combinational shift and rotate stage for the integer pipeline of a RISC core. The execute stage presents three things: the operand word, the function code of the instruction, and a single rotate-select bit from the instruction. It also presents two shift amounts. One is a 5-bit amount taken from the instruction itself. The other is a register operand whose low five bits give a variable amount.

The unit first decodes the function code into three choices: a direction, a fill policy (zero, sign or wrap-around), and an amount source. A single logarithmic right-shifting network then produces the result. Left shifts reuse that network by mirroring the operand bits on the way in and on the way out.

Rotate has no function code of its own. It shares the code of the matching logical right shift, and the select bit chooses between the two. A valid flag tells the pipeline whether the function code names one of the shift operations. When it does not, the result is forced to zero.

Top module: `shrot_unit`

## Requirements
- R1: Function code 6'h00 yields `op_word` shifted left logically by `imm_amt`, with zeros entering at bit 0.
- R2: Function code 6'h02 with `rot_sel` = 0 yields `op_word` shifted right logically by `imm_amt`, with zeros entering at bit 31.
- R3: Function code 6'h02 with `rot_sel` = 1 yields `op_word` rotated right by `imm_amt`. Bits leaving at bit 0 re-enter at bit 31, so the number of set bits is preserved.
- R4: Function code 6'h03 yields `op_word` shifted right by `imm_amt`, with copies of `op_word[31]` entering at the top.
- R5: Function code 6'h04 yields `op_word` shifted left logically by `reg_amt[4:0]`.
- R6: Function code 6'h06 yields a logical right shift by `reg_amt[4:0]` when `rot_sel` = 0, and a right rotate by `reg_amt[4:0]` when `rot_sel` = 1.
- R7: Function code 6'h07 yields `op_word` shifted right arithmetically by `reg_amt[4:0]`.
- R8: A rotate by an amount of 0, in either the immediate or the register form, returns `op_word` unchanged.
- R9: `valid` is 1 exactly for the function codes 6'h00, 6'h02, 6'h03, 6'h04, 6'h06 and 6'h07. For every other code, `valid` is 0 and `result` is 32'h0.
- R10: Bits 31:5 of `reg_amt` have no effect on `result`.
- R11: `rot_sel` has no effect on `result` for function codes 6'h00, 6'h03, 6'h04 and 6'h07.
- R12: The immediate forms (6'h00, 6'h02, 6'h03) ignore `reg_amt`, and the register forms (6'h04, 6'h06, 6'h07) ignore `imm_amt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_word | input | 32 | Operand word to be shifted or rotated |
| imm_amt | input | 5 | Shift amount from the instruction |
| reg_amt | input | 32 | Register operand; bits 4:0 give the variable amount |
| func | input | 6 | Function code selecting the operation |
| rot_sel | input | 1 | Chooses rotate over logical right shift for codes 6'h02 and 6'h06 |
| result | output | 32 | Shifted or rotated word, or zero when the code is not a shift |
| valid | output | 1 | High when `func` names a shift or rotate operation |

## Verification
The assertions assume that every input port holds a defined two-state value whenever they are evaluated. They also assume the inputs have settled, because a combinational check made in the middle of a partial update would compare a stale amount against a fresh operand. The bench keeps within these assumptions in two ways. It changes all inputs together at the falling clock edge and reads the outputs one nanosecond later. It also never leaves an input undriven. The stimulus sweeps every function code and the amounts 0, 1, 31 and values in between, using operands with the sign bit both set and clear. Junk is placed in the unused amount source and in the upper register bits so that the cases where an input must be ignored are actually exercised.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int DATA_W  = 32;
    localparam int FUNC_W  = 6;
    localparam int AMT_W   = $clog2(DATA_W);

    localparam logic [FUNC_W-1:0] FN_LSL_I = 6'h00;
    localparam logic [FUNC_W-1:0] FN_LSR_I = 6'h02;
    localparam logic [FUNC_W-1:0] FN_ASR_I = 6'h03;
    localparam logic [FUNC_W-1:0] FN_LSL_R = 6'h04;
    localparam logic [FUNC_W-1:0] FN_LSR_R = 6'h06;
    localparam logic [FUNC_W-1:0] FN_ASR_R = 6'h07;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  ok;
        logic  mirror;
        logic  from_reg;
        fill_e fill;
    } shctl_t;

    function automatic logic [DATA_W-1:0] mirror_bits(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = x[DATA_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int FW = FUNC_W
) (
    input  logic [FW-1:0] func,
    input  logic          rot_sel,
    output shctl_t        ctl
);

    always_comb begin
        ctl = '{ok: 1'b0, mirror: 1'b0, from_reg: 1'b0, fill: FILL_ZERO};
        unique case (func)
            FN_LSL_I: ctl = '{ok: 1'b1, mirror: 1'b1, from_reg: 1'b0, fill: FILL_ZERO};
            FN_LSR_I: ctl = '{ok: 1'b1, mirror: 1'b0, from_reg: 1'b0,
                              fill: rot_sel ? FILL_WRAP : FILL_ZERO};
            FN_ASR_I: ctl = '{ok: 1'b1, mirror: 1'b0, from_reg: 1'b0, fill: FILL_SIGN};
            FN_LSL_R: ctl = '{ok: 1'b1, mirror: 1'b1, from_reg: 1'b1, fill: FILL_ZERO};
            FN_LSR_R: ctl = '{ok: 1'b1, mirror: 1'b0, from_reg: 1'b1,
                              fill: rot_sel ? FILL_WRAP : FILL_ZERO};
            FN_ASR_R: ctl = '{ok: 1'b1, mirror: 1'b0, from_reg: 1'b1, fill: FILL_SIGN};
            default:  ctl = '{ok: 1'b0, mirror: 1'b0, from_reg: 1'b0, fill: FILL_ZERO};
        endcase
    end

endmodule

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  fill_e         fill,
    output logic [W-1:0]  dout
);

    localparam int STAGES = AW;

    logic [W-1:0] stg [0:STAGES];
    logic         sign_bit;

    assign sign_bit = din[W-1];
    assign stg[0]   = din;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        localparam int SH = 1 << gi;
        logic [SH-1:0] fill_bits;

        always_comb begin
            unique case (fill)
                FILL_WRAP: fill_bits = stg[gi][SH-1:0];
                FILL_SIGN: fill_bits = {SH{sign_bit}};
                default:   fill_bits = '0;
            endcase
        end

        assign stg[gi+1] = amt[gi] ? {fill_bits, stg[gi][W-1:SH]} : stg[gi];
    end

    assign dout = stg[STAGES];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic [DATA_W-1:0] op_word,
    input  logic [AMT_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    input  logic [FUNC_W-1:0] func,
    input  logic              rot_sel,
    output logic [DATA_W-1:0] result,
    output logic              valid
);

    shctl_t            ctl;
    logic [AMT_W-1:0]  amt_sel;
    logic [DATA_W-1:0] net_in;
    logic [DATA_W-1:0] net_out;

    shrot_decode #(.FW(FUNC_W)) u_decode (
        .func    (func),
        .rot_sel (rot_sel),
        .ctl     (ctl)
    );

    assign amt_sel = ctl.from_reg ? reg_amt[AMT_W-1:0] : imm_amt;
    assign net_in  = ctl.mirror ? mirror_bits(op_word) : op_word;

    shrot_core #(.W(DATA_W), .AW(AMT_W)) u_core (
        .din  (net_in),
        .amt  (amt_sel),
        .fill (ctl.fill),
        .dout (net_out)
    );

    always_comb begin
        if (!ctl.ok)        result = '0;
        else if (ctl.mirror) result = mirror_bits(net_out);
        else                 result = net_out;
    end

    assign valid = ctl.ok;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
    import shrot_pkg::*;
(
    input logic [DATA_W-1:0] op_word,
    input logic [AMT_W-1:0]  imm_amt,
    input logic [DATA_W-1:0] reg_amt,
    input logic [FUNC_W-1:0] func,
    input logic              rot_sel,
    input logic [DATA_W-1:0] result,
    input logic              valid
);

    logic is_rot;
    logic [AMT_W-1:0] eff_amt;

    always_comb begin
        is_rot  = rot_sel && ((func == 6'h02) || (func == 6'h06));
        eff_amt = (func == 6'h06) ? reg_amt[AMT_W-1:0] : imm_amt;
    end

    always_comb begin
        // R9: a non-shift code leaves the result at zero
        p_invalid_zero_r9: assert (valid || (result == '0));
        // R3: a rotation moves bits around without losing any
        p_rot_keeps_ones_r3: assert (!is_rot || ($countones(result) == $countones(op_word)));
        // R8: rotating by zero is the identity
        p_rot_zero_ident_r8: assert (!(is_rot && eff_amt == '0) || (result == op_word));
        // R1: a nonzero left shift always clears bit 0
        p_lsl_low_clear_r1: assert (!(func == 6'h00 && imm_amt != '0) || !result[0]);
        // R4: arithmetic right shifts keep the sign
        p_asr_sign_r4: assert (!(func == 6'h03 || func == 6'h07) || (result[DATA_W-1] == op_word[DATA_W-1]));
    end

endmodule

bind shrot_unit shrot_unit_chk u_chk (
    .op_word (op_word),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .func    (func),
    .rot_sel (rot_sel),
    .result  (result),
    .valid   (valid)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_word = '0;
    logic [4:0]  imm_amt = '0;
    logic [31:0] reg_amt = '0;
    logic [5:0]  func = '0;
    logic        rot_sel = 1'b0;
    logic [31:0] result;
    logic        valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shrot_unit u_dut (
        .op_word (op_word),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .func    (func),
        .rot_sel (rot_sel),
        .result  (result),
        .valid   (valid)
    );

    // Expected value built from the requirement text alone
    function automatic logic [32:0] model(input logic [31:0] x, input logic [4:0] ia,
                                          input logic [31:0] ra, input logic [5:0] f,
                                          input logic rs);
        logic [4:0]  n;
        logic [31:0] r;
        logic        ok;
        n  = (f >= 6'h04) ? ra[4:0] : ia;
        ok = 1'b1;
        case (f)
            6'h00, 6'h04: r = x << n;
            6'h02, 6'h06: begin
                if (rs) r = (n == 0) ? x : ((x >> n) | (x << (6'd32 - {1'b0, n})));
                else    r = x >> n;
            end
            6'h03, 6'h07: r = $unsigned($signed(x) >>> n);
            default: begin r = 32'h0; ok = 1'b0; end
        endcase
        return {ok, r};
    endfunction

    task automatic apply_check(input string tag, input logic [31:0] x, input logic [4:0] ia,
                               input logic [31:0] ra, input logic [5:0] f, input logic rs);
        logic [32:0] exp;
        @(negedge clk);
        op_word = x; imm_amt = ia; reg_amt = ra; func = f; rot_sel = rs;
        exp = model(x, ia, ra, f, rs);
        #1;
        n_chk++;
        if ({valid, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: func=%h sel=%b x=%h ia=%0d ra=%h actual valid=%b result=%h expected valid=%b result=%h",
                     tag, f, rs, x, ia, ra, valid, result, exp[32], exp[31:0]);
        end
    endtask

    task automatic t_idle();
        apply_check("R1 idle zero", 32'h0, 5'd0, 32'h0, 6'h00, 1'b0);
    endtask

    task automatic t_imm_forms();
        apply_check("R1 lsl 1", 32'h8000_0001, 5'd1, 32'h0, 6'h00, 1'b0);
        apply_check("R1 lsl 31", 32'h0000_0003, 5'd31, 32'h0, 6'h00, 1'b0);
        apply_check("R1 lsl 12", 32'hDEAD_BEEF, 5'd12, 32'h0, 6'h00, 1'b0);
        apply_check("R2 lsr 4", 32'hF000_000F, 5'd4, 32'h0, 6'h02, 1'b0);
        apply_check("R2 lsr 31", 32'h8000_0000, 5'd31, 32'h0, 6'h02, 1'b0);
        apply_check("R3 ror 8", 32'h1234_5678, 5'd8, 32'h0, 6'h02, 1'b1);
        apply_check("R3 ror 1", 32'h0000_0001, 5'd1, 32'h0, 6'h02, 1'b1);
        apply_check("R3 ror 31", 32'h8000_0001, 5'd31, 32'h0, 6'h02, 1'b1);
        apply_check("R4 asr neg 7", 32'h8765_4321, 5'd7, 32'h0, 6'h03, 1'b0);
        apply_check("R4 asr pos 7", 32'h7765_4321, 5'd7, 32'h0, 6'h03, 1'b0);
        apply_check("R4 asr neg 31", 32'h8000_0000, 5'd31, 32'h0, 6'h03, 1'b0);
    endtask

    task automatic t_reg_forms();
        apply_check("R5 lslv 9", 32'h0F0F_0F0F, 5'd0, 32'd9, 6'h04, 1'b0);
        apply_check("R5 lslv 31", 32'hFFFF_FFFF, 5'd0, 32'd31, 6'h04, 1'b0);
        apply_check("R6 lsrv 17", 32'hCAFE_F00D, 5'd0, 32'd17, 6'h06, 1'b0);
        apply_check("R6 rorv 17", 32'hCAFE_F00D, 5'd0, 32'd17, 6'h06, 1'b1);
        apply_check("R6 rorv 3", 32'h0000_0005, 5'd0, 32'd3, 6'h06, 1'b1);
        apply_check("R7 asrv neg 20", 32'hA000_0000, 5'd0, 32'd20, 6'h07, 1'b0);
        apply_check("R7 asrv pos 2", 32'h4000_0004, 5'd0, 32'd2, 6'h07, 1'b0);
    endtask

    task automatic t_rot_zero();
        apply_check("R8 ror imm 0", 32'hA5A5_0FF0, 5'd0, 32'h0, 6'h02, 1'b1);
        apply_check("R8 rorv reg 0", 32'h1357_9BDF, 5'd7, 32'hFFFF_FFE0, 6'h06, 1'b1);
    endtask

    task automatic t_all_codes();
        for (int f = 0; f < 64; f++) begin
            apply_check("R9 code sweep", 32'hFEDC_BA98, 5'd5, 32'd11, f[5:0], 1'b0);
            apply_check("R9 code sweep sel", 32'h0123_4567, 5'd13, 32'd2, f[5:0], 1'b1);
        end
    endtask

    task automatic t_upper_bits();
        apply_check("R10 lslv upper junk", 32'h0000_00FF, 5'd0, 32'hFFFF_FFE4, 6'h04, 1'b0);
        apply_check("R10 rorv upper junk", 32'h8000_00FF, 5'd0, 32'h1234_5665, 6'h06, 1'b1);
        apply_check("R10 asrv upper junk", 32'h8000_0000, 5'd0, 32'hAAAA_AA81, 6'h07, 1'b0);
    endtask

    task automatic t_sel_ignored();
        apply_check("R11 lsl sel", 32'h8000_0001, 5'd3, 32'h0, 6'h00, 1'b1);
        apply_check("R11 asr sel", 32'h8000_0010, 5'd3, 32'h0, 6'h03, 1'b1);
        apply_check("R11 lslv sel", 32'hC000_0001, 5'd0, 32'd2, 6'h04, 1'b1);
        apply_check("R11 asrv sel", 32'h8000_0001, 5'd0, 32'd4, 6'h07, 1'b1);
    endtask

    task automatic t_cross_source();
        apply_check("R12 imm lsl ignores reg", 32'h0000_0001, 5'd4, 32'd20, 6'h00, 1'b0);
        apply_check("R12 imm ror ignores reg", 32'h0000_00F1, 5'd4, 32'd9, 6'h02, 1'b1);
        apply_check("R12 imm asr ignores reg", 32'hF000_0000, 5'd2, 32'd30, 6'h03, 1'b0);
        apply_check("R12 reg lslv ignores imm", 32'h0000_0001, 5'd30, 32'd1, 6'h04, 1'b0);
        apply_check("R12 reg lsrv ignores imm", 32'h8000_0000, 5'd30, 32'd1, 6'h06, 1'b0);
        apply_check("R12 reg asrv ignores imm", 32'h8000_0000, 5'd30, 32'd1, 6'h07, 1'b0);
    endtask

    initial begin
        #10 rst_n = 1'b1;
        t_idle();
        t_imm_forms();
        t_reg_forms();
        t_rot_zero();
        t_all_codes();
        t_upper_bits();
        t_sel_ignored();
        t_cross_source();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule